// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller Core

This core collects up to 32 interrupt lines into a pending-status register and routes them to a processor through two request outputs, a normal one and a critical one. Each line is set to edge or level sensing. A pending line requests service only when its enable bit is set, and a per-line steering bit sends it to either the normal or the critical output. Software reaches the registers over a simple bus made of an offset, write data, a write strobe, a read strobe and read data. Reads are combinational and return zero when the read strobe is low.

Software clears pending bits at one offset and sets them at another. A clear puts back any level-sensed line that is still active, so such a line cannot be lost. Line n is held in bit (31 − n) of every per-line register, so line 0 is the most significant bit. The core gives an external vector generator the set of enabled critical lines that are pending. It also holds that generator's configuration word and shows the vector the generator returns. Input synchronisation and the vector arithmetic are done outside the core.

Top module: `ictl_core`

## Requirements
- R1: After reset, the status, enable, steering, polarity, trigger-mode, vector-config and vector offsets all read zero, and both request outputs are low.
- R2: Input line n sets status bit (31 − n). Line 0 maps to bit 31 and line 5 maps to bit 26.
- R3: A line whose trigger-mode bit (offset 5) is 1 is edge sensed. A 0-to-1 change on the line sets its status bit one clock later, and the bit stays set after the line returns low.
- R4: A line whose trigger-mode bit is 0 is level sensed. When the line changes, both its status bit and an internal level bit take the new value one clock later.
- R5: A write to offset 0 clears every status bit written as 1 and then ORs the internal level bits back in. A level line that is still high stays pending.
- R6: A write to offset 1 ORs the written data into status. Reads at offset 0 and at offset 1 both return status.
- R7: `irq_o` is high when (status AND enable AND NOT steering) is nonzero. `crit_irq_o` is high when (status AND enable AND steering) is nonzero. `crit_pend_o` carries that last AND. Enable is at offset 2 and steering at offset 3.
- R8: A read at offset 6 returns status AND enable. Writes to offsets 6 and 7 change nothing.
- R9: The polarity word at offset 4 reads back what was written and does not affect status or the outputs.
- R10: Offsets 9 to 15 read zero, and `rdata_o` is zero whenever `re_i` is low.
- R11: With vectoring on, a write to offset 8 stores the data with bit 1 forced to 0, and this value drives `vec_cfg_o`. Offset 7 returns `vec_i` while `crit_irq_o` is high and returns zero otherwise.
- R12: With the VEC_EN parameter at 0, offsets 7 and 8 read zero.
- R13: If an edge-line rising transition and a status-clear write of the same bit fall in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt lines, already synchronised; line n is src_i[n] |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |
| crit_pend_o | output | 32 | Enabled critical pending lines, for the vector generator |
| vec_cfg_o | output | 32 | Vector generator configuration |
| vec_i | input | 32 | Vector from the generator |

## Verification
A wrong status bit shows up on the next read of offset 0, 1 or 6, and on `irq_o` or `crit_irq_o` one clock after the event that caused it. A stale level bit, or a stale copy of a line's previous value, appears only later: on the next clear, where a bit comes back that should not, or on the next transition, where an edge is missed or a phantom edge appears. For this reason the bench runs several clears and transitions in sequence on the same lines. The clash between an edge and a clear in one clock is tested directly, because only the result in that single cycle shows which one takes priority.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int unsigned OFF_STAT  = 0;
  localparam int unsigned OFF_SET   = 1;
  localparam int unsigned OFF_EN    = 2;
  localparam int unsigned OFF_STEER = 3;
  localparam int unsigned OFF_POL   = 4;
  localparam int unsigned OFF_TRIG  = 5;
  localparam int unsigned OFF_MSK   = 6;
  localparam int unsigned OFF_VEC   = 7;
  localparam int unsigned OFF_VCFG  = 8;
  localparam int unsigned VCFG_ZERO_BIT = 1;
endpackage

// File: rtl/ictl_edge_det.sv
module ictl_edge_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  assign rise_o = in_i & ~prev_q;
  assign chg_o  = in_i ^ prev_q;
endmodule

// File: rtl/ictl_status_bank.sv
module ictl_status_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] chg_i,
  input  logic [N-1:0] trig_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] level_o
);
  logic [N-1:0] status_q, level_q, sw_nxt;

  // software update first; line events override it below
  always_comb begin
    sw_nxt = status_q;
    if (clr_we_i)      sw_nxt = (status_q & ~wdata_i) | level_q;
    else if (set_we_i) sw_nxt = status_q | wdata_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_d, lv_d;
    always_comb begin
      st_d = sw_nxt[i];
      lv_d = level_q[i];
      if (trig_i[i]) begin
        if (rise_i[i]) st_d = 1'b1;
      end else if (chg_i[i]) begin
        st_d = in_i[i];
        lv_d = in_i[i];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        status_q[i] <= 1'b0;
        level_q[i]  <= 1'b0;
      end else begin
        status_q[i] <= st_d;
        level_q[i]  <= lv_d;
      end
    end
  end

  assign status_o = status_q;
  assign level_o  = level_q;
endmodule

// File: rtl/ictl_cfg_regs.sv
module ictl_cfg_regs
  import ictl_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4,
  parameter bit          VEC_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      enable_o,
  output logic [N-1:0]      steer_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      trig_o,
  output logic [N-1:0]      vcfg_o
);
  localparam logic [N-1:0] VCFG_MASK = ~(N'(1) << VCFG_ZERO_BIT);

  logic [N-1:0] en_q, steer_q, pol_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      steer_q <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(OFF_EN))    en_q    <= wdata_i;
      if (addr_i == ADDR_W'(OFF_STEER)) steer_q <= wdata_i;
      if (addr_i == ADDR_W'(OFF_POL))   pol_q   <= wdata_i;
      if (addr_i == ADDR_W'(OFF_TRIG))  trig_q  <= wdata_i;
    end
  end

  if (VEC_EN) begin : g_vcfg
    logic [N-1:0] vcfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vcfg_q <= '0;
      else if (we_i && addr_i == ADDR_W'(OFF_VCFG)) vcfg_q <= wdata_i & VCFG_MASK;
    end
    assign vcfg_o = vcfg_q;
  end else begin : g_no_vcfg
    assign vcfg_o = '0;
  end

  assign enable_o = en_q;
  assign steer_o  = steer_q;
  assign pol_o    = pol_q;
  assign trig_o   = trig_q;
endmodule

// File: rtl/ictl_core.sv
module ictl_core
  import ictl_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4,
  parameter bit          VEC_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [N-1:0]      rdata_o,
  output logic              irq_o,
  output logic              crit_irq_o,
  output logic [N-1:0]      crit_pend_o,
  output logic [N-1:0]      vec_cfg_o,
  input  logic [N-1:0]      vec_i
);
  logic [N-1:0] src_b, rise, chg, status_q, level_q;
  logic [N-1:0] enable, steer, pol, trig, vcfg;
  logic [N-1:0] masked, rd_mux;

  // line n -> bit N-1-n
  for (genvar n = 0; n < N; n++) begin : g_map
    assign src_b[N-1-n] = src_i[n];
  end

  ictl_edge_det #(.N(N)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .in_i(src_b), .rise_o(rise), .chg_o(chg)
  );

  ictl_cfg_regs #(.N(N), .ADDR_W(ADDR_W), .VEC_EN(VEC_EN)) u_cfg (
    .clk_i   (clk_i),   .rst_ni (rst_ni), .we_i  (we_i),
    .addr_i  (addr_i),  .wdata_i(wdata_i),
    .enable_o(enable),  .steer_o(steer),  .pol_o (pol),
    .trig_o  (trig),    .vcfg_o (vcfg)
  );

  ictl_status_bank #(.N(N)) u_stat (
    .clk_i   (clk_i),  .rst_ni (rst_ni),
    .in_i    (src_b),  .rise_i (rise),   .chg_i (chg), .trig_i(trig),
    .clr_we_i(we_i && addr_i == ADDR_W'(OFF_STAT)),
    .set_we_i(we_i && addr_i == ADDR_W'(OFF_SET)),
    .wdata_i (wdata_i),
    .status_o(status_q), .level_o(level_q)
  );

  assign masked      = status_q & enable;
  assign crit_pend_o = masked & steer;
  assign crit_irq_o  = |crit_pend_o;
  assign irq_o       = |(masked & ~steer);
  assign vec_cfg_o   = vcfg;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      ADDR_W'(OFF_STAT), ADDR_W'(OFF_SET): rd_mux = status_q;
      ADDR_W'(OFF_EN):    rd_mux = enable;
      ADDR_W'(OFF_STEER): rd_mux = steer;
      ADDR_W'(OFF_POL):   rd_mux = pol;
      ADDR_W'(OFF_TRIG):  rd_mux = trig;
      ADDR_W'(OFF_MSK):   rd_mux = masked;
      ADDR_W'(OFF_VEC):   rd_mux = (VEC_EN && crit_irq_o) ? vec_i : '0;
      ADDR_W'(OFF_VCFG):  rd_mux = vcfg;
      default:            rd_mux = '0;
    endcase
  end

  assign rdata_o = re_i ? rd_mux : '0;
endmodule

// File: rtl/ictl_core_chk.sv
module ictl_core_chk
  import ictl_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      src_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic              we_i,
  input logic [N-1:0]      trig_i,
  input logic [N-1:0]      level_i,
  input logic [N-1:0]      status_i,
  input logic [N-1:0]      enable_i,
  input logic              irq_o,
  input logic              crit_irq_o
);
  logic [N-1:0] src_b, prev_b, rise_m, lchg_m, set_m, clr_m;
  logic armed_q;

  for (genvar n = 0; n < N; n++) begin : g_map
    assign src_b[N-1-n] = src_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_b  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_b  <= src_b;
      armed_q <= 1'b1;
    end
  end

  assign rise_m = trig_i & src_b & ~prev_b;
  assign lchg_m = ~trig_i & (src_b ^ prev_b);
  assign set_m  = (we_i && addr_i == ADDR_W'(OFF_SET)) ? (wdata_i & ~lchg_m) : '0;
  assign clr_m  = (we_i && addr_i == ADDR_W'(OFF_STAT)) ? (wdata_i & trig_i & ~rise_m & ~level_i) : '0;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((status_i & $past(rise_m)) == $past(rise_m))); // R3
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (((status_i ^ $past(src_b)) & $past(lchg_m)) == '0)); // R4
  AST_CLEAR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((status_i & $past(clr_m)) == '0)); // R5
  AST_SET_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((status_i & $past(set_m)) == $past(set_m))); // R6
  AST_QUIET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |-> (!irq_o && !crit_irq_o)); // R7
endmodule

bind ictl_core ictl_core_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),   .rst_ni  (rst_ni),  .src_i   (src_i),
  .addr_i  (addr_i),  .wdata_i (wdata_i), .we_i    (we_i),
  .trig_i  (trig),    .level_i (level_q), .status_i(status_q),
  .enable_i(enable),  .irq_o   (irq_o),   .crit_irq_o(crit_irq_o)
);

// File: tb/ictl_core_tb.sv
`timescale 1ns/1ps
module ictl_core_tb;
  localparam int N = 32;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SRC = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } step_t;

  localparam int NSTEP = 36;
  localparam step_t STEPS [NSTEP] = '{
    '{K_SRC, 4'd0, 32'h0000_0001, 32'h0},          // line 0 high, level
    '{K_RD,  4'd0, 32'h0, 32'h8000_0000},          // R2 R4
    '{K_RD,  4'd1, 32'h0, 32'h8000_0000},          // R6
    '{K_SRC, 4'd0, 32'h0000_0000, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_0000},          // R4
    '{K_SRC, 4'd0, 32'h0000_0020, 32'h0},          // line 5
    '{K_RD,  4'd0, 32'h0, 32'h0400_0000},          // R2
    '{K_SRC, 4'd0, 32'h0000_0000, 32'h0},
    '{K_WR,  4'd5, 32'h0000_0001, 32'h0},          // line 31 edge
    '{K_RD,  4'd5, 32'h0, 32'h0000_0001},
    '{K_SRC, 4'd0, 32'h8000_0000, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_0001},          // R3
    '{K_SRC, 4'd0, 32'h0000_0000, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_0001},          // R3 held
    '{K_WR,  4'd0, 32'h0000_0001, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_0000},          // R5
    '{K_SRC, 4'd0, 32'h0000_0001, 32'h0},
    '{K_WR,  4'd0, 32'hFFFF_FFFF, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h8000_0000},          // R5 reassert
    '{K_SRC, 4'd0, 32'h0000_0000, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_0000},
    '{K_WR,  4'd1, 32'h0000_00F0, 32'h0},
    '{K_RD,  4'd0, 32'h0, 32'h0000_00F0},          // R6
    '{K_RD,  4'd1, 32'h0, 32'h0000_00F0},          // R6
    '{K_WR,  4'd2, 32'h0000_0030, 32'h0},
    '{K_RD,  4'd6, 32'h0, 32'h0000_0030},          // R8
    '{K_WR,  4'd6, 32'h0000_FFFF, 32'h0},
    '{K_WR,  4'd7, 32'h0000_FFFF, 32'h0},
    '{K_RD,  4'd6, 32'h0, 32'h0000_0030},          // R8 ignored
    '{K_RD,  4'd0, 32'h0, 32'h0000_00F0},          // R8
    '{K_WR,  4'd4, 32'h0000_A5A5, 32'h0},
    '{K_RD,  4'd4, 32'h0, 32'h0000_A5A5},          // R9
    '{K_RD,  4'd0, 32'h0, 32'h0000_00F0},          // R9 no effect
    '{K_RD,  4'd9, 32'h0, 32'h0000_0000},          // R10
    '{K_RD,  4'd15, 32'h0, 32'h0000_0000},         // R10
    '{K_RD,  4'd2, 32'h0, 32'h0000_0030}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] src_i = '0, wdata_i = '0, vec_i = '0;
  logic [3:0] addr_i = '0;
  logic we_i = 1'b0, re_i = 1'b0;
  logic [N-1:0] rdata_o, crit_pend_o, vec_cfg_o, rdata_nv, pend_nv, cfg_nv;
  logic irq_o, crit_irq_o, irq_nv, crit_nv;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ictl_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .crit_irq_o(crit_irq_o), .crit_pend_o(crit_pend_o),
    .vec_cfg_o(vec_cfg_o), .vec_i(vec_i)
  );

  ictl_core #(.VEC_EN(1'b0)) u_dut_nv (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .re_i(re_i), .rdata_o(rdata_nv),
    .irq_o(irq_nv), .crit_irq_o(crit_nv), .crit_pend_o(pend_nv),
    .vec_cfg_o(cfg_nv), .vec_i(vec_i)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    re_i = 1'b1; addr_i = a;
    #1 check(req, rdata_o, exp);
    re_i = 1'b0;
  endtask

  task automatic drive_src(logic [31:0] v);
    @(negedge clk);
    src_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a <= 8; a++) rd(4'(a), 32'h0, "R1");
    #1 check("R1 irq", {30'h0, irq_o, crit_irq_o}, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      case (STEPS[i].kind)
        K_WR:  wr(STEPS[i].addr, STEPS[i].data);
        K_SRC: drive_src(STEPS[i].data);
        default: rd(STEPS[i].addr, STEPS[i].exp, $sformatf("R%0d step %0d", 0, i));
      endcase
    end

    // R7 steering: status F0, enable 30, steer 0
    #1 check("R7 normal", {30'h0, irq_o, crit_irq_o}, 32'h2);
    wr(4'd3, 32'h0000_0010);
    #1 check("R7 both", {30'h0, irq_o, crit_irq_o}, 32'h3);
    check("R7 pend", crit_pend_o, 32'h0000_0010);
    wr(4'd2, 32'h0000_0010);
    #1 check("R7 crit only", {30'h0, irq_o, crit_irq_o}, 32'h1);

    // R10 read strobe low
    @(negedge clk); addr_i = 4'd0; re_i = 1'b0;
    #1 check("R10 re low", rdata_o, 32'h0);

    // R11 vector path
    vec_i = 32'h0000_1234;
    rd(4'd7, 32'h0000_1234, "R11 vec");
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, 32'hFFFF_FFFD, "R11 cfg");
    check("R11 cfg out", vec_cfg_o, 32'hFFFF_FFFD);
    // R12 no-vector variant
    @(negedge clk); re_i = 1'b1; addr_i = 4'd8;
    #1 check("R12 cfg", rdata_nv, 32'h0);
    addr_i = 4'd7;
    #1 check("R12 vec", rdata_nv, 32'h0);
    re_i = 1'b0;
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, 32'h0, "R11 vec idle");
    #1 check("R7 idle", {30'h0, irq_o, crit_irq_o}, 32'h0);

    // R13 edge rise together with clear of same bit
    wr(4'd1, 32'h0000_0001);
    @(negedge clk);
    src_i = 32'h8000_0000; we_i = 1'b1; addr_i = 4'd0; wdata_i = 32'h1;
    @(negedge clk); we_i = 1'b0;
    rd(4'd0, 32'h0000_0001, "R13");
    wr(4'd0, 32'h0000_0001);
    rd(4'd0, 32'h0000_0000, "R3 no rise");

    // R1 reset mid-run
    drive_src(32'h0);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(4'd0, 32'h0, "R1 stat");
    rd(4'd2, 32'h0, "R1 en");
    rd(4'd4, 32'h0, "R1 pol");
    rd(4'd5, 32'h0, "R1 trig");
    rd(4'd8, 32'h0, "R1 vcfg");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule